// File: doc/BRIEF.md
# Translation Unit Control and Status Registers

This block is the software-facing control plane of an address-translation unit. A 32-bit register bus reads and writes a small register file: the base of the page directory, a live status word, a write-only command port, the address of the last translation fault, a single-page invalidate port, the interrupt registers (raw, mask, clear, masked) and a clock-gating enable. The page-table walker is outside the block. It reports faults, bus errors, idleness and the state of its replay buffer. In return the block tells the walker whether paging is on and whether it must hold.

Paging, stall and fault are three separate states that lock one another out. A stall request takes effect only once the walker is idle. A stall request made while a fault is outstanding is dropped. With paging off the walker is held as well. A hard-reset command returns every register to its power-on value, and software can detect this by reading the directory base back as zero.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: A write to offset 0x00 stores the directory base with bits 11:0 forced to zero (writing 0xCAFEBABE reads back 0xCAFEB000), and the value appears on `dir_base_o`.
- R2: Writing command code 0 to offset 0x08 enables paging and code 1 disables it. Status bit 0 shows the paging state, and `hold_o` is high whenever paging is off.
- R3: Command code 2 requests a stall. Status bit 2 rises only on a cycle after the walker reports idle. Command code 3 drops the stall at once. Status bit 31 always reads as the inverse of bit 2, and status bit 3 mirrors `walker_idle_i`.
- R4: A stall request (code 2) issued while a fault is active is discarded, and the stall does not appear later.
- R5: A fault pulse is accepted only while paging is on and no fault is active. When accepted it sets status bit 1, records the write flag in status bit 5, records the 5-bit requester id in status bits 10:6 and the faulting address at offset 0x0C, sets raw interrupt bit 0, and holds the walker.
- R6: Command code 5 clears status bit 1 and strobes `flt_resume_o` during the write. The recorded write flag and id stay visible.
- R7: A bus-error pulse sets raw interrupt bit 1 (offset 0x14). Both raw bits can be pending together.
- R8: Offset 0x20 reads raw AND mask (mask at 0x1C, bits 1:0), and `irq_o` is high exactly when that result is non-zero.
- R9: Writing a 1 to a bit at offset 0x18 clears that raw bit. Bits written as 0 are kept.
- R10: Command code 4 strobes `inv_all_o` during the write. A write to offset 0x10 strobes `inv_line_o` with the written address, bits 11:0 cleared, on `inv_line_addr_o`.
- R11: Command code 6 returns the directory base, mask, raw status, gating bit, paging, stall and fault fields to zero.
- R12: A command word other than 0 to 6 changes no state.
- R13: Bit 0 at offset 0x24 is a read/write clock-gating enable that drives `gate_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register byte offset |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, combinational |
| walker_idle_i | input | 1 | Walker has no request in flight |
| replay_empty_i | input | 1 | Walker replay buffer is empty |
| flt_v_i | input | 1 | Translation fault pulse |
| flt_addr_i | input | DW (32) | Faulting virtual address |
| flt_wr_i | input | 1 | Faulting access was a write |
| flt_id_i | input | ID_W (5) | Bus id of the faulting requester |
| bus_err_i | input | 1 | Walker read bus-error pulse |
| irq_o | output | 1 | Interrupt, any masked status bit set |
| paging_o | output | 1 | Paging enabled |
| hold_o | output | 1 | Walker must not issue |
| dir_base_o | output | DW (32) | Page directory base |
| inv_all_o | output | 1 | Invalidate the whole translation cache |
| inv_line_o | output | 1 | Invalidate one page entry |
| inv_line_addr_o | output | DW (32) | Page address for `inv_line_o` |
| flt_resume_o | output | 1 | Fault acknowledged, walker may resume |
| gate_en_o | output | 1 | Automatic clock gating enable |

## Verification
A wrong interlock shows first in the status word and in `hold_o`. A stall accepted during a fault leaves bit 2 set after the fault is acknowledged. A stall that ignores idleness sets bit 2 while the walker is still busy. Both are visible on the first read after the command. Errors in the interrupt path show on `irq_o` in the cycle after the event, mask write or clear write. An incomplete hard reset shows on the next read of the directory base, mask or gating register.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

   // register byte offsets (software-visible map)
   localparam logic [7:0] OFS_DIR    = 8'h00;
   localparam logic [7:0] OFS_STAT   = 8'h04;
   localparam logic [7:0] OFS_CMD    = 8'h08;
   localparam logic [7:0] OFS_FADDR  = 8'h0C;
   localparam logic [7:0] OFS_INVLN  = 8'h10;
   localparam logic [7:0] OFS_RAW    = 8'h14;
   localparam logic [7:0] OFS_CLR    = 8'h18;
   localparam logic [7:0] OFS_MASK   = 8'h1C;
   localparam logic [7:0] OFS_MSKD   = 8'h20;
   localparam logic [7:0] OFS_GATE   = 8'h24;

   // command codes
   typedef enum logic [2:0] {
      CMD_PG_ON    = 3'd0,
      CMD_PG_OFF   = 3'd1,
      CMD_ST_ON    = 3'd2,
      CMD_ST_OFF   = 3'd3,
      CMD_INV_ALL  = 3'd4,
      CMD_FLT_DONE = 3'd5,
      CMD_HARD_RST = 3'd6
   } mmu_cmd_e;

   typedef struct packed {
      logic pg_on;
      logic pg_off;
      logic st_on;
      logic st_off;
      logic inv_all;
      logic flt_done;
      logic hard_rst;
   } cmd_strobe_t;

   // status bit positions
   localparam int unsigned ST_PAGING = 0;
   localparam int unsigned ST_FAULT  = 1;
   localparam int unsigned ST_STALL  = 2;
   localparam int unsigned ST_IDLE   = 3;
   localparam int unsigned ST_REPLAY = 4;
   localparam int unsigned ST_FWRITE = 5;
   localparam int unsigned ST_ID_LSB = 6;

   // interrupt source positions
   localparam int unsigned IRQ_FAULT = 0;
   localparam int unsigned IRQ_BUSER = 1;
   localparam int unsigned NUM_IRQ   = 2;

endpackage

// File: rtl/mmu_cmd_decode.sv
module mmu_cmd_decode
   import mmu_regs_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          cmd_wr,
   input  logic [DW-1:0] wdata,
   output cmd_strobe_t   cmd
);
   localparam int unsigned CODE_W = 3;

   logic code_ok;
   logic [CODE_W-1:0] code;

   assign code    = wdata[CODE_W-1:0];
   // whole word must be a legal code; anything else is dropped
   assign code_ok = cmd_wr && (wdata[DW-1:CODE_W] == '0) && (code != 3'd7);

   always_comb begin
      cmd = '0;
      if (code_ok) begin
         case (mmu_cmd_e'(code))
            CMD_PG_ON    : cmd.pg_on    = 1'b1;
            CMD_PG_OFF   : cmd.pg_off   = 1'b1;
            CMD_ST_ON    : cmd.st_on    = 1'b1;
            CMD_ST_OFF   : cmd.st_off   = 1'b1;
            CMD_INV_ALL  : cmd.inv_all  = 1'b1;
            CMD_FLT_DONE : cmd.flt_done = 1'b1;
            CMD_HARD_RST : cmd.hard_rst = 1'b1;
            default      : cmd = '0;
         endcase
      end
   end
endmodule

// File: rtl/mmu_mode_fsm.sv
module mmu_mode_fsm
   import mmu_regs_pkg::*;
#(
   parameter int unsigned VA_W = 32,
   parameter int unsigned ID_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  cmd_strobe_t     cmd,
   input  logic            walker_idle_i,
   input  logic            flt_v_i,
   input  logic [VA_W-1:0] flt_addr_i,
   input  logic            flt_wr_i,
   input  logic [ID_W-1:0] flt_id_i,
   output logic            paging_q,
   output logic            stall_req_q,
   output logic            stall_act_q,
   output logic            flt_act_q,
   output logic [VA_W-1:0] flt_addr_q,
   output logic            flt_wr_q,
   output logic [ID_W-1:0] flt_id_q,
   output logic            flt_take
);
   // a fault is only taken while translating and none is outstanding
   assign flt_take = flt_v_i & paging_q & ~flt_act_q & ~cmd.hard_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paging_q    <= 1'b0;
         stall_req_q <= 1'b0;
         stall_act_q <= 1'b0;
         flt_act_q   <= 1'b0;
         flt_addr_q  <= '0;
         flt_wr_q    <= 1'b0;
         flt_id_q    <= '0;
      end else if (cmd.hard_rst) begin
         paging_q    <= 1'b0;
         stall_req_q <= 1'b0;
         stall_act_q <= 1'b0;
         flt_act_q   <= 1'b0;
         flt_addr_q  <= '0;
         flt_wr_q    <= 1'b0;
         flt_id_q    <= '0;
      end else begin
         if (cmd.pg_on)
            paging_q <= 1'b1;
         else if (cmd.pg_off)
            paging_q <= 1'b0;

         if (cmd.st_on && !flt_act_q)
            stall_req_q <= 1'b1;
         else if (cmd.st_off)
            stall_req_q <= 1'b0;

         // stall becomes visible once the walker has drained
         stall_act_q <= stall_req_q & (stall_act_q | walker_idle_i) & ~cmd.st_off;

         if (flt_take) begin
            flt_act_q  <= 1'b1;
            flt_addr_q <= flt_addr_i;
            flt_wr_q   <= flt_wr_i;
            flt_id_q   <= flt_id_i;
         end else if (cmd.flt_done) begin
            flt_act_q  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mmu_irq_bank.sv
module mmu_irq_bank #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic [N-1:0] ev,
   input  logic         clr_we,
   input  logic         mask_we,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] raw_q,
   output logic [N-1:0] mask_q
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            raw_q[i]  <= 1'b0;
            mask_q[i] <= 1'b0;
         end else if (soft_clr) begin
            raw_q[i]  <= 1'b0;
            mask_q[i] <= 1'b0;
         end else begin
            // a new event beats a clear in the same cycle
            if (ev[i])
               raw_q[i] <= 1'b1;
            else if (clr_we && wbits[i])
               raw_q[i] <= 1'b0;
            if (mask_we)
               mask_q[i] <= wbits[i];
         end
      end
   end
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
   import mmu_regs_pkg::*;
#(
   parameter int unsigned AW   = 6,
   parameter int unsigned DW   = 32,
   parameter int unsigned ID_W = 5,
   parameter int unsigned PG   = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   input  logic            walker_idle_i,
   input  logic            replay_empty_i,
   input  logic            flt_v_i,
   input  logic [DW-1:0]   flt_addr_i,
   input  logic            flt_wr_i,
   input  logic [ID_W-1:0] flt_id_i,
   input  logic            bus_err_i,
   output logic            irq_o,
   output logic            paging_o,
   output logic            hold_o,
   output logic [DW-1:0]   dir_base_o,
   output logic            inv_all_o,
   output logic            inv_line_o,
   output logic [DW-1:0]   inv_line_addr_o,
   output logic            flt_resume_o,
   output logic            gate_en_o
);
   localparam int unsigned HI_W = DW - PG;

   if (DW != 32) begin : g_bad_dw
      $error("mmu_ctrl_regs: DW must be 32 for the status layout");
   end
   if (ST_ID_LSB + ID_W > DW - 1) begin : g_bad_id
      $error("mmu_ctrl_regs: ID_W overlaps the stall-clear status bit");
   end
   if (AW < 6) begin : g_bad_aw
      $error("mmu_ctrl_regs: AW too small for the register map");
   end
   if (PG >= DW) begin : g_bad_pg
      $error("mmu_ctrl_regs: PG must be below DW");
   end

   // address decode
   logic hit_dir, hit_cmd, hit_invln, hit_clr, hit_mask, hit_gate;
   assign hit_dir   = reg_we && (reg_addr == AW'(OFS_DIR));
   assign hit_cmd   = reg_we && (reg_addr == AW'(OFS_CMD));
   assign hit_invln = reg_we && (reg_addr == AW'(OFS_INVLN));
   assign hit_clr   = reg_we && (reg_addr == AW'(OFS_CLR));
   assign hit_mask  = reg_we && (reg_addr == AW'(OFS_MASK));
   assign hit_gate  = reg_we && (reg_addr == AW'(OFS_GATE));

   cmd_strobe_t cmd;

   mmu_cmd_decode #(.DW(DW)) i_dec (
      .cmd_wr (hit_cmd),
      .wdata  (reg_wdata),
      .cmd    (cmd)
   );

   logic            paging, stall_req, stall_act, flt_act, flt_wr, flt_take;
   logic [DW-1:0]   flt_addr;
   logic [ID_W-1:0] flt_id;

   mmu_mode_fsm #(.VA_W(DW), .ID_W(ID_W)) i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd           (cmd),
      .walker_idle_i (walker_idle_i),
      .flt_v_i       (flt_v_i),
      .flt_addr_i    (flt_addr_i),
      .flt_wr_i      (flt_wr_i),
      .flt_id_i      (flt_id_i),
      .paging_q      (paging),
      .stall_req_q   (stall_req),
      .stall_act_q   (stall_act),
      .flt_act_q     (flt_act),
      .flt_addr_q    (flt_addr),
      .flt_wr_q      (flt_wr),
      .flt_id_q      (flt_id),
      .flt_take      (flt_take)
   );

   logic [NUM_IRQ-1:0] irq_ev, raw, mask, masked;

   always_comb begin
      irq_ev            = '0;
      irq_ev[IRQ_FAULT] = flt_take;
      irq_ev[IRQ_BUSER] = bus_err_i & ~cmd.hard_rst;
   end

   mmu_irq_bank #(.N(NUM_IRQ)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (cmd.hard_rst),
      .ev       (irq_ev),
      .clr_we   (hit_clr),
      .mask_we  (hit_mask),
      .wbits    (reg_wdata[NUM_IRQ-1:0]),
      .raw_q    (raw),
      .mask_q   (mask)
   );

   assign masked = raw & mask;
   assign irq_o  = |masked;

   // directory base and gating enable
   logic [HI_W-1:0] dir_hi;
   logic            gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_hi <= '0;
         gate_q <= 1'b0;
      end else if (cmd.hard_rst) begin
         dir_hi <= '0;
         gate_q <= 1'b0;
      end else begin
         if (hit_dir)
            dir_hi <= reg_wdata[DW-1:PG];
         if (hit_gate)
            gate_q <= reg_wdata[0];
      end
   end

   assign dir_base_o      = {dir_hi, {PG{1'b0}}};
   assign gate_en_o       = gate_q;
   assign paging_o        = paging;
   assign hold_o          = ~paging | stall_act | flt_act;
   assign inv_all_o       = cmd.inv_all;
   assign flt_resume_o    = cmd.flt_done;
   assign inv_line_o      = hit_invln;
   assign inv_line_addr_o = {reg_wdata[DW-1:PG], {PG{1'b0}}};

   // live status word
   logic [DW-1:0] status;
   always_comb begin
      status                          = '0;
      status[ST_PAGING]               = paging;
      status[ST_FAULT]                = flt_act;
      status[ST_STALL]                = stall_act;
      status[ST_IDLE]                 = walker_idle_i;
      status[ST_REPLAY]               = replay_empty_i;
      status[ST_FWRITE]               = flt_wr;
      status[ST_ID_LSB +: ID_W]       = flt_id;
      status[DW-1]                    = ~stall_act;
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(OFS_DIR)   : reg_rdata = dir_base_o;
         AW'(OFS_STAT)  : reg_rdata = status;
         AW'(OFS_FADDR) : reg_rdata = flt_addr;
         AW'(OFS_RAW)   : reg_rdata = DW'(raw);
         AW'(OFS_MASK)  : reg_rdata = DW'(mask);
         AW'(OFS_MSKD)  : reg_rdata = DW'(masked);
         AW'(OFS_GATE)  : reg_rdata = DW'(gate_q);
         default        : reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
module mmu_ctrl_regs_chk #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 32,
   parameter int unsigned PG = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic          walker_idle_i,
   input logic          flt_v_i,
   input logic          bus_err_i,
   input logic [DW-1:0] dir_base_o,
   input logic          paging_o,
   input logic          irq_o,
   input logic          stall_req,
   input logic          stall_act,
   input logic          flt_act
);
   logic          is_cmd;
   logic [DW-1:0] lo_clr;

   assign is_cmd = reg_we && (reg_addr == AW'(8'h08));
   assign lo_clr = ~DW'((64'd1 << PG) - 64'd1);

   // R1
   dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(8'h00)) |=> (dir_base_o == ($past(reg_wdata) & lo_clr)));

   // R11
   hard_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && reg_wdata == DW'(6)) |=> (dir_base_o == '0 && !paging_o && !irq_o && !flt_act));

   // R3
   stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_act) |-> $past(walker_idle_i));

   // R4
   stall_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && reg_wdata == DW'(2) && flt_act && !stall_req) |=> !stall_req);

   // R6
   flt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && reg_wdata == DW'(5) && (flt_act || !flt_v_i)) |=> !flt_act);

   // R5
   flt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_v_i && paging_o && !flt_act && !(is_cmd && reg_wdata == DW'(6))) |=> flt_act);

   // R9
   clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(8'h18) && reg_wdata[1:0] == 2'b11 && !flt_v_i && !bus_err_i)
      |=> !irq_o);
endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk #(.AW(AW), .DW(DW), .PG(PG)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_addr      (reg_addr),
   .reg_wdata     (reg_wdata),
   .walker_idle_i (walker_idle_i),
   .flt_v_i       (flt_v_i),
   .bus_err_i     (bus_err_i),
   .dir_base_o    (dir_base_o),
   .paging_o      (paging_o),
   .irq_o         (irq_o),
   .stall_req     (stall_req),
   .stall_act     (stall_act),
   .flt_act       (flt_act)
);

// File: tb/test_mmu_ctrl_regs.sv
`timescale 1ns/1ps
module test_mmu_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        walker_idle_i = 1'b0;
   logic        replay_empty_i = 1'b0;
   logic        flt_v_i = 1'b0;
   logic [31:0] flt_addr_i = '0;
   logic        flt_wr_i = 1'b0;
   logic [4:0]  flt_id_i = '0;
   logic        bus_err_i = 1'b0;
   logic        irq_o, paging_o, hold_o, inv_all_o, inv_line_o, flt_resume_o, gate_en_o;
   logic [31:0] dir_base_o, inv_line_addr_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   mmu_ctrl_regs i_mmu_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .walker_idle_i(walker_idle_i), .replay_empty_i(replay_empty_i),
      .flt_v_i(flt_v_i), .flt_addr_i(flt_addr_i), .flt_wr_i(flt_wr_i),
      .flt_id_i(flt_id_i), .bus_err_i(bus_err_i), .irq_o(irq_o),
      .paging_o(paging_o), .hold_o(hold_o), .dir_base_o(dir_base_o),
      .inv_all_o(inv_all_o), .inv_line_o(inv_line_o),
      .inv_line_addr_o(inv_line_addr_o), .flt_resume_o(flt_resume_o),
      .gate_en_o(gate_en_o)
   );

   // scoreboard
   logic [31:0] exp_q[$];
   string       tag_q[$];
   bit          rd_act = 1'b0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rd_act && exp_q.size() > 0) begin
         chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
   end

   task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
      @(posedge clk); #1;
      reg_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_act = 1'b1;
      @(negedge clk); #0.5;
      rd_act = 1'b0;
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic pulse_fault(logic [31:0] a, logic w, logic [4:0] id);
      @(posedge clk); #1;
      flt_v_i = 1'b1; flt_addr_i = a; flt_wr_i = w; flt_id_i = id;
      @(posedge clk); #1;
      flt_v_i = 1'b0;
   endtask

   task automatic pulse_berr();
      @(posedge clk); #1;
      bus_err_i = 1'b1;
      @(posedge clk); #1;
      bus_err_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state
      rd(6'h04, 32'h8000_0000, "R3 reset status");
      rd(6'h00, 32'h0, "R1 reset dir");
      chk("R2 reset hold", {31'b0, hold_o}, 32'd1);
      chk("R8 reset irq", {31'b0, irq_o}, 32'd0);

      wr(6'h00, 32'hCAFE_BABE);
      rd(6'h00, 32'hCAFE_B000, "R1 dir readback");
      chk("R1 dir port", dir_base_o, 32'hCAFE_B000);

      wr(6'h08, 32'd0);
      rd(6'h04, 32'h8000_0001, "R2 paging on");
      chk("R2 hold released", {31'b0, hold_o}, 32'd0);

      wr(6'h08, 32'd2);
      cyc();
      rd(6'h04, 32'h8000_0001, "R3 stall waits busy walker");
      walker_idle_i = 1'b1;
      cyc();
      rd(6'h04, 32'h0000_000D, "R3 stall active after idle");
      chk("R3 hold while stalled", {31'b0, hold_o}, 32'd1);
      wr(6'h08, 32'd3);
      rd(6'h04, 32'h8000_0009, "R3 stall dropped");

      wr(6'h08, 32'd7);
      rd(6'h04, 32'h8000_0009, "R12 code 7 ignored");
      wr(6'h08, 32'h100);
      rd(6'h04, 32'h8000_0009, "R12 wide word ignored");

      pulse_fault(32'h1234_5678, 1'b1, 5'h15);
      rd(6'h04, 32'h8000_056B, "R5 fault status");
      rd(6'h0C, 32'h1234_5678, "R5 fault address");
      rd(6'h14, 32'h1, "R5 raw fault bit");
      chk("R5 hold on fault", {31'b0, hold_o}, 32'd1);
      chk("R8 masked off irq", {31'b0, irq_o}, 32'd0);

      wr(6'h08, 32'd2);
      cyc(); cyc();
      rd(6'h04, 32'h8000_056B, "R4 stall refused in fault");

      wr(6'h1C, 32'h3);
      rd(6'h20, 32'h1, "R8 masked status");
      chk("R8 irq raised", {31'b0, irq_o}, 32'd1);
      pulse_berr();
      rd(6'h14, 32'h3, "R7 two pending");
      rd(6'h20, 32'h3, "R8 masked both");
      wr(6'h18, 32'h1);
      rd(6'h14, 32'h2, "R9 clear fault bit only");
      chk("R8 irq from bus error", {31'b0, irq_o}, 32'd1);
      wr(6'h1C, 32'h1);
      rd(6'h20, 32'h0, "R8 mask hides bus error");
      chk("R8 irq masked low", {31'b0, irq_o}, 32'd0);
      wr(6'h1C, 32'h3);
      wr(6'h18, 32'h2);
      rd(6'h14, 32'h0, "R9 raw cleared");
      chk("R9 irq low", {31'b0, irq_o}, 32'd0);

      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = 6'h08; reg_wdata = 32'd5;
      #1 chk("R6 resume strobe", {31'b0, flt_resume_o}, 32'd1);
      @(posedge clk); #1; reg_we = 1'b0;
      rd(6'h04, 32'h8000_0569, "R6 fault cleared, stall stays off");
      chk("R6 hold released", {31'b0, hold_o}, 32'd0);

      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = 6'h08; reg_wdata = 32'd4;
      #1 chk("R10 invalidate all", {31'b0, inv_all_o}, 32'd1);
      @(posedge clk); #1; reg_we = 1'b0;
      #1 chk("R10 invalidate all ends", {31'b0, inv_all_o}, 32'd0);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = 6'h10; reg_wdata = 32'hABCD_E123;
      #1 chk("R10 line strobe", {31'b0, inv_line_o}, 32'd1);
      chk("R10 line address", inv_line_addr_o, 32'hABCD_E000);
      @(posedge clk); #1; reg_we = 1'b0;

      wr(6'h24, 32'h1);
      rd(6'h24, 32'h1, "R13 gating readback");
      chk("R13 gating port", {31'b0, gate_en_o}, 32'd1);

      pulse_berr();
      chk("R7 irq before hard reset", {31'b0, irq_o}, 32'd1);
      wr(6'h08, 32'd6);
      rd(6'h00, 32'h0, "R11 dir zero");
      rd(6'h04, 32'h8000_0008, "R11 status power-on");
      rd(6'h14, 32'h0, "R11 raw zero");
      rd(6'h1C, 32'h0, "R11 mask zero");
      rd(6'h24, 32'h0, "R11 gating zero");
      chk("R11 irq low", {31'b0, irq_o}, 32'd0);

      pulse_fault(32'h0000_4000, 1'b0, 5'h3);
      rd(6'h04, 32'h8000_0008, "R5 fault ignored without paging");
      rd(6'h14, 32'h0, "R5 no raw bit without paging");

      wr(6'h08, 32'd0);
      wr(6'h08, 32'd1);
      rd(6'h04, 32'h8000_0008, "R2 paging off");
      chk("R2 hold with paging off", {31'b0, hold_o}, 32'd1);

      cyc();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule